// File: doc/BRIEF.md
# Dual-Pattern Serial Bit Detector

This block watches a one-bit serial stream and flags two bit patterns with a single shared Moore state machine. The short pattern is 0,0,0,1 and the long pattern is 0,0,0,1,0, both listed oldest bit first. The short pattern is a prefix of the long one. Each has its own one-bit detect output, and both outputs are decoded from the present state alone. A strobe marks the cycles that carry a real bit. In cycles without the strobe, the machine holds its progress.

Matching overlaps. After a hit, the machine keeps the longest tail of the stream that can still begin a pattern, so any run of three or more zeros followed by a one fires the short detect again. An asynchronous active-low reset clears the machine at once. Its release is synchronised to the clock, and bits that arrive before the release finishes are not consumed. Any state code outside the used set returns to idle on the next clock edge.

Top module: `dual_seq_detector`

## Requirements
- R1: `hit_short` is high in the cycle after the rising edge that samples a valid bit completing 0,0,0,1 (oldest bit first). It is not high after any other valid bit.
- R2: `hit_long` is high in the cycle after the rising edge that samples a valid bit completing 0,0,0,1,0 (oldest bit first).
- R3: Matching overlaps. The valid stream 0,0,0,1,0,0,0,0,1,0 produces two `hit_short` pulses and two `hit_long` pulses, each one cycle after its final bit.
- R4: An edge with `bit_valid` low leaves both outputs unchanged and keeps partial progress. For example, 0,0 followed by a stall, then 0, a stall and 1, still fires `hit_short`.
- R5: The outputs depend only on the state. Changing `bit_in` or `bit_valid` between clock edges does not change either output until the next edge.
- R6: Each detect is cleared by the next valid bit unless that bit completes a match for the same output. In this design that never happens, so each match gives exactly one high cycle when bits arrive back to back.
- R7: `hit_long` only rises when `hit_short` was high in the cycle before.
- R8: `hit_short` and `hit_long` are never high in the same cycle.
- R9: While `rst_n` is low, both outputs are low at once and all bit history is cleared. After `rst_n` rises, the valid bit offered on the first falling edge is ignored, and consumption starts with the following bit.
- R10: A 1 that arrives after fewer than three consecutive zeros clears progress. For example, 0,0,1,0,0,0,1 gives exactly one `hit_short`, on the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bits are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bit_valid | input | 1 | High when `bit_in` carries a bit to consume |
| bit_in | input | 1 | Serial data bit |
| hit_short | output | 1 | Moore detect for 0,0,0,1 |
| hit_long | output | 1 | Moore detect for 0,0,0,1,0 |

## Verification
Two functions can fall in the same cycle: holding state during a stall, and clearing a detect after its one-cycle pulse. They meet when `bit_valid` drops right after a completing bit. The bench provokes this by stalling for several cycles on a terminal state and then resuming with a 0, which must turn a held short detect into a long detect. It also stalls on a long detect. A bench reference model, built from the last five valid bits, expects each detect to persist through every stall and to clear only at the next valid bit. A long pseudo-random run with frequent stalls mixes both functions further.

// File: rtl/dpd_pkg.sv
`timescale 1ns/1ps
package dpd_pkg;

  localparam int STATE_W = 3;

  // Each state names the longest stream tail that is still a pattern prefix.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,  // no useful tail
    ST_Z1    = 3'd1,  // tail 0
    ST_Z2    = 3'd2,  // tail 00
    ST_Z3    = 3'd3,  // tail 000 (or longer run of zeros)
    ST_HIT_S = 3'd4,  // tail 0001  -> short detect
    ST_HIT_L = 3'd5   // tail 00010 -> long detect
  } dpd_state_e;

endpackage

// File: rtl/dpd_rst_sync.sv
`timescale 1ns/1ps
module dpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dpd_next_state.sv
`timescale 1ns/1ps
module dpd_next_state
  import dpd_pkg::*;
(
  input  dpd_state_e cur_st,
  input  logic       bit_in,
  output dpd_state_e nxt_st
);

  always_comb begin
    nxt_st = ST_IDLE;
    case (cur_st)
      ST_IDLE:  nxt_st = bit_in ? ST_IDLE  : ST_Z1;
      ST_Z1:    nxt_st = bit_in ? ST_IDLE  : ST_Z2;
      ST_Z2:    nxt_st = bit_in ? ST_IDLE  : ST_Z3;
      ST_Z3:    nxt_st = bit_in ? ST_HIT_S : ST_Z3;
      ST_HIT_S: nxt_st = bit_in ? ST_IDLE  : ST_HIT_L;
      // tail after 00010 is a single 0, so a further 0 gives tail 00
      ST_HIT_L: nxt_st = bit_in ? ST_IDLE  : ST_Z2;
      default:  nxt_st = ST_IDLE;  // unused codes recover
    endcase
  end

endmodule

// File: rtl/dpd_state_reg.sv
`timescale 1ns/1ps
module dpd_state_reg #(
  parameter int             W         = 3,
  parameter logic [W-1:0]   RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_VAL;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/dpd_out_decode.sv
`timescale 1ns/1ps
module dpd_out_decode
  import dpd_pkg::*;
(
  input  dpd_state_e cur_st,
  output logic       hit_short,
  output logic       hit_long,
  output logic       st_legal
);

  always_comb begin
    hit_short = 1'b0;
    hit_long  = 1'b0;
    st_legal  = 1'b1;
    case (cur_st)
      ST_HIT_S: hit_short = 1'b1;
      ST_HIT_L: hit_long  = 1'b1;
      ST_IDLE, ST_Z1, ST_Z2, ST_Z3: ;
      default:  st_legal  = 1'b0;
    endcase
  end

endmodule

// File: rtl/dual_seq_detector.sv
`timescale 1ns/1ps
module dual_seq_detector
  import dpd_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic hit_short,
  output logic hit_long
);

  logic               rst_core_n;
  dpd_state_e         cur_st;
  dpd_state_e         nxt_st;
  logic               st_legal;
  logic               st_load;
  logic [STATE_W-1:0] st_q;

  dpd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  dpd_next_state u_next (
    .cur_st (cur_st),
    .bit_in (bit_in),
    .nxt_st (nxt_st)
  );

  // clock enable: a valid bit, or recovery from an unused code
  assign st_load = bit_valid | ~st_legal;

  dpd_state_reg #(.W(STATE_W), .RESET_VAL(ST_IDLE)) u_state (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (st_load),
    .d     (nxt_st),
    .q     (st_q)
  );

  assign cur_st = dpd_state_e'(st_q);

  dpd_out_decode u_dec (
    .cur_st    (cur_st),
    .hit_short (hit_short),
    .hit_long  (hit_long),
    .st_legal  (st_legal)
  );

  // ---------------- assertions ----------------
  assert_short_after_one_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(hit_short) |-> $past(bit_valid && bit_in));

  assert_long_follows_zero_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bit_valid && hit_short && !bit_in) |=> hit_long);

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!bit_valid && st_legal) |=> $stable({hit_short, hit_long}));

  assert_short_single_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bit_valid && hit_short) |=> !hit_short);

  assert_long_single_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bit_valid && hit_long) |=> !hit_long);

  assert_long_after_short_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(hit_long) |-> $past(hit_short));

  assert_exclusive_hits_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(hit_short && hit_long));

endmodule

// File: tb/dual_seq_detector_bench.sv
`timescale 1ns/1ps
module dual_seq_detector_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_valid;
  logic bit_in;
  logic hit_short;
  logic hit_long;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] exp_q[$];
  logic [1:0] last_exp = 2'b00;
  logic [4:0] hist     = 5'b0;
  int         cnt      = 0;

  always #2 clk = ~clk;  // 250 MHz

  dual_seq_detector u_dual_seq_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .hit_short (hit_short),
    .hit_long  (hit_long)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {short,long}=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of input, updates reference model, queues expectation
  task automatic drive(input logic v, input logic b, input bit ignored);
    logic [1:0] e;
    @(negedge clk);
    bit_valid = v;
    bit_in    = b;
    #0.5;
    check("R5 outputs fixed between edges", {hit_short, hit_long}, last_exp);
    if (v && !ignored) begin
      hist = {hist[3:0], b};
      if (cnt < 5) cnt++;
    end
    e[1] = (cnt >= 4) && (hist[3:0] == 4'b0001);
    e[0] = (cnt >= 5) && (hist == 5'b00010);
    exp_q.push_back(e);
    last_exp = e;
  endtask

  task automatic send(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) drive(1'b1, bits[i], 1'b0);
  endtask

  task automatic stall(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, i[0], 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #0.5;
    rst_n     = 1'b0;
    bit_valid = 1'b0;
    #0.5;
    check("R9 outputs low during reset", {hit_short, hit_long}, 2'b00);
    hist = '0; cnt = 0; last_exp = 2'b00;
    repeat (3) @(negedge clk);
    check("R9 outputs low held in reset", {hit_short, hit_long}, 2'b00);
    rst_n = 1'b1;
    // first bit after release falls inside the synchroniser window
    drive(1'b1, 1'b0, 1'b1);
  endtask

  // monitor: compare queued expectations after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      logic [1:0] e;
      e = exp_q.pop_front();
      check("R1 R2 R3 R6 R10 detect vs model", {hit_short, hit_long}, e);
      if (hit_short && hit_long) check("R8 exclusive", 2'b11, 2'b00);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n     = 1'b0;
    bit_valid = 1'b0;
    bit_in    = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset state", {hit_short, hit_long}, 2'b00);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b1);       // R9: ignored bit during release
    send(16'b001, 3);              // no hit if the ignored 0 was dropped
    stall(1);
    // R3 overlap stream
    send(16'b0001000010, 10);
    stall(2);
    // R4 stall on a short hit, then resume into a long hit, stall again
    send(16'b0001, 4);
    stall(3);
    send(16'b0, 1);
    stall(2);
    send(16'b1, 1);
    // R4 partial progress kept over stalls
    send(16'b00, 2);
    stall(1);
    send(16'b0, 1);
    stall(2);
    send(16'b1, 1);
    // R10 early one clears progress
    send(16'b1111, 4);
    send(16'b0010001, 7);
    send(16'b00001, 5);
    send(16'b000010, 6);
    send(16'b0001, 4);
    send(16'b0001, 4);
    // pseudo-random mix with stalls
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[0] | lf[3], lf[2] & lf[9], 1'b0);
    end
    // R9 reset in the middle of a match
    send(16'b0001, 4);
    do_reset();
    send(16'b001, 3);
    send(16'b00010, 5);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule